// File: doc/BRIEF.md
# Word ALU with Status Flag Update

This block is the arithmetic and logic stage of a 16-bit processor with a byte-wide status register. Each accepted request supplies a source operand, a destination operand, an operation code, a byte/word select and the current status byte. One clock later the block returns the result, a write-enable that says whether the result goes back to the destination, and the next status byte.

Every operation owns a fixed set of status flags that it may change. All other flags are copied unchanged from the incoming status byte. This lets a core chain instructions through the block without having to rebuild flags that an instruction must not touch. Absolute value is an exception to the result-based flags: it judges the source operand before negation. Byte-capable operations work on the upper byte of each operand, leave the low byte of the destination as it was, and produce odd parity from the byte they handled.

Top module: `alu_status_unit`

## Requirements
- R1: A request with `in_valid` high gives its `res`, `res_we` and `st_out` one clock edge later, with `res_valid` high. On a cycle with `in_valid` low, the following edge drives `res_valid` and `res_we` low and holds `res` and `st_out`. Reset clears all outputs to zero.
- R2: Status bit positions are 7 logical-greater (LGT), 6 arithmetic-greater (AGT), 5 equal (EQ), 4 carry (C), 3 overflow (OV), 2 odd parity (P), 1 extended-op (X) and 0 spare. X is always copied from `st_in`, and bit 0 of `st_out` is always 0.
- R3: Each operation changes only the flags in its own mask, and every other flag equals the corresponding bit of `st_in`. The masks are:
  - add, subtract, negate, increment and decrement: LGT AGT EQ C OV
  - compare, invert, OR, AND-NOT, XOR and move: LGT AGT EQ
  - absolute value: LGT AGT EQ OV
  - clear and set-ones: no flags
  - byte-mode add, subtract, compare, OR, AND-NOT and move: their word mask plus P
- R4: Add computes dst+src and subtract computes dst-src. Increment adds 1, increment-by-two adds 2, decrement subtracts 1 and decrement-by-two subtracts 2; these four act on src. C is the carry out of the top bit, which for a subtraction means no borrow. OV is set on signed overflow.
- R5: For every operation other than compare and absolute value, LGT is set when the result is nonzero, AGT when it is positive as a signed number, and EQ when it is zero.
- R6: Compare sets LGT if src > dst unsigned, AGT if src > dst signed, and EQ if they are equal. It drives `res_we` low and returns dst as `res`.
- R7: Invert returns ~src and changes only LGT, AGT and EQ. C, OV and P keep their input values.
- R8: Absolute value returns |src|, and 0x8000 stays 0x8000. It takes LGT, AGT and EQ from src before negation, sets OV only for src = 0x8000, and keeps C.
- R9: Negate returns 0-src, sets C only for src = 0 and sets OV only for src = 0x8000.
- R10: When `byte_sel` is high, add, subtract, compare, OR, AND-NOT and move use bits 15:8 of both operands. The result byte goes to `res[15:8]` and `res[7:0]` equals dst[7:0]. Flags come from the byte, and P is set or cleared as the odd parity of the result byte (of the src byte for compare). For all other operations `byte_sel` has no effect.
- R11: OR returns dst|src, AND-NOT returns dst&~src, XOR returns dst^src, move returns src, clear returns 0 and set-ones returns 0xFFFF.
- R12: Operation codes are: 0 add, 1 subtract, 2 compare, 3 invert, 4 negate, 5 absolute, 6 increment, 7 increment-by-two, 8 decrement, 9 decrement-by-two, 10 OR, 11 AND-NOT, 12 XOR, 13 move, 14 clear, 15 set-ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| op | input | 4 | Operation code |
| byte_sel | input | 1 | Byte mode for byte-capable operations |
| src | input | 16 | Source operand |
| dst | input | 16 | Destination operand |
| st_in | input | 8 | Current status byte |
| res_valid | output | 1 | Result present |
| res | output | 16 | Result word |
| res_we | output | 1 | Result is to be written back |
| st_out | output | 8 | Next status byte |

## Verification
Every result, write-enable and status byte is due exactly one edge after the cycle its request was driven. The bench drives each request on a falling edge and compares all four outputs just after the next rising edge. A behavioural model in the bench predicts that cycle's values.

An idle cycle is checked the same way: one edge later, the valid and write-enable outputs are low and the held values have not moved. The sweep runs every operation against every pair of corner operands. It does so in both word and byte mode, and from two starting status bytes: EQ alone, and LGT, AGT, C, OV and P together.

// File: rtl/alu_status_pkg.sv
package alu_status_pkg;

   localparam int STAT_W = 8;
   localparam int OP_W   = 4;

   // status bit positions, most significant first
   localparam int F_LGT = 7;
   localparam int F_AGT = 6;
   localparam int F_EQ  = 5;
   localparam int F_CY  = 4;
   localparam int F_OV  = 3;
   localparam int F_PAR = 2;
   localparam int F_XOP = 1;
   localparam int F_NC  = 0;

   localparam logic [STAT_W-1:0] M_LGT = STAT_W'(1) << F_LGT;
   localparam logic [STAT_W-1:0] M_AGT = STAT_W'(1) << F_AGT;
   localparam logic [STAT_W-1:0] M_EQ  = STAT_W'(1) << F_EQ;
   localparam logic [STAT_W-1:0] M_CY  = STAT_W'(1) << F_CY;
   localparam logic [STAT_W-1:0] M_OV  = STAT_W'(1) << F_OV;
   localparam logic [STAT_W-1:0] M_PAR = STAT_W'(1) << F_PAR;
   localparam logic [STAT_W-1:0] M_NC  = STAT_W'(1) << F_NC;

   localparam logic [STAT_W-1:0] M_CMPSET = M_LGT | M_AGT | M_EQ;
   localparam logic [STAT_W-1:0] M_ARITH  = M_CMPSET | M_CY | M_OV;

   typedef enum logic [OP_W-1:0] {
      OP_ADD  = 4'd0,
      OP_SUB  = 4'd1,
      OP_CMP  = 4'd2,
      OP_INV  = 4'd3,
      OP_NEG  = 4'd4,
      OP_ABS  = 4'd5,
      OP_INC  = 4'd6,
      OP_INCT = 4'd7,
      OP_DEC  = 4'd8,
      OP_DECT = 4'd9,
      OP_OR   = 4'd10,
      OP_ANDN = 4'd11,
      OP_XOR  = 4'd12,
      OP_MOV  = 4'd13,
      OP_CLR  = 4'd14,
      OP_SETO = 4'd15
   } alu_op_e;

endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
   parameter int W = 16
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout,
   output logic         ovf
);
   if (W < 2) begin : g_bad_width
      $error("alu_adder: W must be at least 2");
   end

   logic [W:0] wide;

   assign wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
   assign sum  = wide[W-1:0];
   assign cout = wide[W];
   assign ovf  = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
endmodule

// File: rtl/alu_value_flags.sv
module alu_value_flags #(
   parameter int W = 16
) (
   input  logic [W-1:0] val,
   output logic         nonzero,
   output logic         positive,
   output logic         zero,
   output logic         odd
);
   if (W < 2) begin : g_bad_width
      $error("alu_value_flags: W must be at least 2");
   end

   assign zero     = (val == '0);
   assign nonzero  = !zero;
   assign positive = !val[W-1] && !zero;
   assign odd      = ^val;
endmodule

// File: rtl/alu_flag_mask.sv
module alu_flag_mask
   import alu_status_pkg::*;
(
   input  alu_op_e             op,
   input  logic                byte_mode,
   output logic [STAT_W-1:0]   mask
);
   logic [STAT_W-1:0] base;

   always_comb begin
      unique case (op)
         OP_ADD, OP_SUB, OP_NEG,
         OP_INC, OP_INCT, OP_DEC, OP_DECT:   base = M_ARITH;
         OP_ABS:                             base = M_CMPSET | M_OV;
         OP_CMP, OP_INV, OP_OR, OP_ANDN,
         OP_XOR, OP_MOV:                     base = M_CMPSET;
         OP_CLR, OP_SETO:                    base = '0;
         default:                            base = '0;
      endcase
   end

   // parity joins the mask only for byte results; the spare bit never does
   assign mask = (base | (byte_mode ? M_PAR : '0)) & ~M_NC;
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
   import alu_status_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int LANE_W = 8
) (
   input  alu_op_e             op,
   input  logic                byte_sel,
   input  logic [DATA_W-1:0]   src,
   input  logic [DATA_W-1:0]   dst,
   output logic [DATA_W-1:0]   result,
   output logic                wr_en,
   output logic                byte_mode,
   output logic [STAT_W-1:0]   flags
);
   localparam int LANE_LSB = DATA_W - LANE_W;
   localparam int MSB      = DATA_W - 1;

   if (LANE_W < 2 || LANE_W >= DATA_W) begin : g_bad_lane
      $error("alu_datapath: LANE_W must lie in [2, DATA_W)");
   end

   // ---------------- byte mode qualification ----------------
   always_comb begin
      unique case (op)
         OP_ADD, OP_SUB, OP_CMP, OP_OR, OP_ANDN, OP_MOV: byte_mode = byte_sel;
         default:                                        byte_mode = 1'b0;
      endcase
   end

   // ---------------- word adder operand steering ----------------
   logic [DATA_W-1:0] wa, wb, wsum;
   logic              wci, wco, wov;

   always_comb begin
      wa  = src;
      wb  = '0;
      wci = 1'b0;
      unique case (op)
         OP_ADD:         begin wa = dst; wb = src;  end
         OP_SUB:         begin wa = dst; wb = ~src; wci = 1'b1; end
         OP_NEG, OP_ABS: begin wa = '0;  wb = ~src; wci = 1'b1; end
         OP_INC:         wb = DATA_W'(1);
         OP_INCT:        wb = DATA_W'(2);
         OP_DEC:         wb = '1;
         OP_DECT:        wb = ~DATA_W'(1);
         default:        ;
      endcase
   end

   alu_adder #(.W(DATA_W)) u_word_add (
      .a(wa), .b(wb), .cin(wci), .sum(wsum), .cout(wco), .ovf(wov)
   );

   // ---------------- upper-lane adder ----------------
   logic [LANE_W-1:0] s_hi, d_hi, lb, lsum;
   logic              lci, lco, lov;

   assign s_hi = src[MSB -: LANE_W];
   assign d_hi = dst[MSB -: LANE_W];
   assign lci  = (op == OP_SUB);
   assign lb   = lci ? ~s_hi : s_hi;

   alu_adder #(.W(LANE_W)) u_lane_add (
      .a(d_hi), .b(lb), .cin(lci), .sum(lsum), .cout(lco), .ovf(lov)
   );

   // ---------------- results ----------------
   logic [DATA_W-1:0] w_res;
   logic [LANE_W-1:0] l_res;

   always_comb begin
      unique case (op)
         OP_ADD, OP_SUB, OP_NEG,
         OP_INC, OP_INCT, OP_DEC, OP_DECT: w_res = wsum;
         OP_CMP:  w_res = dst;
         OP_INV:  w_res = ~src;
         OP_ABS:  w_res = src[MSB] ? wsum : src;
         OP_OR:   w_res = dst | src;
         OP_ANDN: w_res = dst & ~src;
         OP_XOR:  w_res = dst ^ src;
         OP_MOV:  w_res = src;
         OP_CLR:  w_res = '0;
         OP_SETO: w_res = '1;
         default: w_res = '0;
      endcase
   end

   always_comb begin
      unique case (op)
         OP_ADD, OP_SUB: l_res = lsum;
         OP_OR:          l_res = d_hi | s_hi;
         OP_ANDN:        l_res = d_hi & ~s_hi;
         OP_MOV:         l_res = s_hi;
         default:        l_res = d_hi;
      endcase
   end

   assign result = byte_mode ? {l_res, dst[LANE_LSB-1:0]} : w_res;
   assign wr_en  = (op != OP_CMP);

   // ---------------- flag sources ----------------
   logic wr_nz, wr_pos, wr_z, wr_odd;
   logic lr_nz, lr_pos, lr_z, lr_odd;
   logic sv_nz, sv_pos, sv_z, sv_odd;
   logic sl_nz, sl_pos, sl_z, sl_odd;

   alu_value_flags #(.W(DATA_W)) u_wres_flags (
      .val(w_res), .nonzero(wr_nz), .positive(wr_pos), .zero(wr_z), .odd(wr_odd)
   );
   alu_value_flags #(.W(LANE_W)) u_lres_flags (
      .val(l_res), .nonzero(lr_nz), .positive(lr_pos), .zero(lr_z), .odd(lr_odd)
   );
   alu_value_flags #(.W(DATA_W)) u_src_flags (
      .val(src), .nonzero(sv_nz), .positive(sv_pos), .zero(sv_z), .odd(sv_odd)
   );
   alu_value_flags #(.W(LANE_W)) u_shi_flags (
      .val(s_hi), .nonzero(sl_nz), .positive(sl_pos), .zero(sl_z), .odd(sl_odd)
   );

   // operand comparison, word and lane
   logic cw_lgt, cw_agt, cw_eq, cl_lgt, cl_agt, cl_eq;
   assign cw_lgt = src > dst;
   assign cw_agt = $signed(src) > $signed(dst);
   assign cw_eq  = src == dst;
   assign cl_lgt = s_hi > d_hi;
   assign cl_agt = $signed(s_hi) > $signed(d_hi);
   assign cl_eq  = s_hi == d_hi;

   logic f_lgt, f_agt, f_eq, f_cy, f_ov, f_par;

   always_comb begin
      if (op == OP_CMP) begin
         f_lgt = byte_mode ? cl_lgt : cw_lgt;
         f_agt = byte_mode ? cl_agt : cw_agt;
         f_eq  = byte_mode ? cl_eq  : cw_eq;
         f_par = sl_odd;
      end else if (op == OP_ABS) begin
         f_lgt = sv_nz;
         f_agt = sv_pos;
         f_eq  = sv_z;
         f_par = 1'b0;
      end else if (byte_mode) begin
         f_lgt = lr_nz;
         f_agt = lr_pos;
         f_eq  = lr_z;
         f_par = lr_odd;
      end else begin
         f_lgt = wr_nz;
         f_agt = wr_pos;
         f_eq  = wr_z;
         f_par = 1'b0;
      end
      f_cy = byte_mode ? lco : wco;
      f_ov = byte_mode ? lov : wov;
   end

   always_comb begin
      flags        = '0;
      flags[F_LGT] = f_lgt;
      flags[F_AGT] = f_agt;
      flags[F_EQ]  = f_eq;
      flags[F_CY]  = f_cy;
      flags[F_OV]  = f_ov;
      flags[F_PAR] = f_par;
   end

   // unused parity of full source and its wordwise derived flags fold here
   logic unused_ok;
   assign unused_ok = &{1'b0, sv_odd, wr_odd, sl_nz, sl_pos, sl_z};
endmodule

// File: rtl/alu_status_unit.sv
module alu_status_unit
   import alu_status_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int LANE_W     = 8,
   parameter bit OUTPUT_REG = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [OP_W-1:0]     op,
   input  logic                byte_sel,
   input  logic [DATA_W-1:0]   src,
   input  logic [DATA_W-1:0]   dst,
   input  logic [STAT_W-1:0]   st_in,
   output logic                res_valid,
   output logic [DATA_W-1:0]   res,
   output logic                res_we,
   output logic [STAT_W-1:0]   st_out
);
   localparam int LANE_LSB = DATA_W - LANE_W;

   if (DATA_W < 4) begin : g_bad_data
      $error("alu_status_unit: DATA_W too small");
   end

   alu_op_e           op_e;
   logic [DATA_W-1:0] dp_res;
   logic              dp_we, dp_byte;
   logic [STAT_W-1:0] dp_flags, mask, next_st;

   assign op_e = alu_op_e'(op);

   alu_datapath #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_dp (
      .op(op_e), .byte_sel(byte_sel), .src(src), .dst(dst),
      .result(dp_res), .wr_en(dp_we), .byte_mode(dp_byte), .flags(dp_flags)
   );

   alu_flag_mask u_mask (
      .op(op_e), .byte_mode(dp_byte), .mask(mask)
   );

   assign next_st = ((st_in & ~mask) | (dp_flags & mask)) & ~M_NC;

   if (OUTPUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            res_valid <= 1'b0;
            res_we    <= 1'b0;
            res       <= '0;
            st_out    <= '0;
         end else begin
            res_valid <= in_valid;
            res_we    <= in_valid && dp_we;
            if (in_valid) begin
               res    <= dp_res;
               st_out <= next_st;
            end
         end
      end

      a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> (!res_valid && !res_we && $stable(res) && $stable(st_out)));

      a_r2_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
         st_out[F_NC] == 1'b0);

      a_r2_xop_kept: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> st_out[F_XOP] == $past(st_in[F_XOP]));

      a_r6_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && op == OP_CMP) |=> (!res_we && res == $past(dst)));

      a_r7_inv_keeps_cop: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && op == OP_INV) |=> st_out[F_CY:F_PAR] == $past(st_in[F_CY:F_PAR]));

      a_r8_abs_keeps_carry: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && op == OP_ABS) |=>
            (st_out[F_CY] == $past(st_in[F_CY]) && st_out[F_PAR] == $past(st_in[F_PAR])));

      a_r10_low_byte_kept: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && byte_sel && (op == OP_ADD || op == OP_SUB || op == OP_MOV)) |=>
            res[LANE_LSB-1:0] == $past(dst[LANE_LSB-1:0]));

      a_r11_fill_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && (op == OP_CLR || op == OP_SETO)) |=>
            st_out == {$past(st_in[STAT_W-1:1]), 1'b0});
   end else begin : g_comb
      assign res_valid = in_valid;
      assign res_we    = in_valid && dp_we;
      assign res       = dp_res;
      assign st_out    = next_st;
   end
endmodule

// File: tb/alu_status_unit_test.sv
`timescale 1ns/1ps
module alu_status_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [3:0]  op = '0;
   logic        byte_sel = 1'b0;
   logic [15:0] src = '0, dst = '0;
   logic [7:0]  st_in = '0;
   logic        res_valid, res_we;
   logic [15:0] res;
   logic [7:0]  st_out;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   alu_status_unit uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .byte_sel(byte_sel),
      .src(src), .dst(dst), .st_in(st_in),
      .res_valid(res_valid), .res(res), .res_we(res_we), .st_out(st_out)
   );

   function automatic int parity(int v);
      int p = 0;
      for (int i = 0; i < 16; i++) p ^= (v >> i) & 1;
      return p;
   endfunction

   function automatic int to_signed(int v, int sb, int md);
      return ((v & sb) != 0) ? v - md : v;
   endfunction

   // behavioural reference built from the requirements
   task automatic model(input int o, input bit bs, input int s, input int d, input int st,
                        output int xr, output bit xwe, output int xst);
      bit bm;
      int md, sb, sh, dh, r, full, msk;
      int lgt, agt, eq, c, ov, par;
      bm = bs && (o == 0 || o == 1 || o == 2 || o == 10 || o == 11 || o == 13);
      md = bm ? 256 : 65536;
      sb = md / 2;
      sh = bm ? (s >> 8) & 255 : s;
      dh = bm ? (d >> 8) & 255 : d;
      c = 0; ov = 0; r = 0;
      case (o)
         0:  begin full = dh + sh; r = full % md; c = int'(full >= md);
                   ov = int'(((dh & sb) == (sh & sb)) && ((r & sb) != (dh & sb))); end
         1:  begin r = (dh - sh + md) % md; c = int'(dh >= sh);
                   ov = int'(((dh & sb) != (sh & sb)) && ((r & sb) != (dh & sb))); end
         2:  r = dh;
         3:  r = (~sh) & (md - 1);
         4:  begin r = (md - sh) % md; c = int'(sh == 0); ov = int'(sh == sb); end
         5:  begin r = ((sh & sb) != 0) ? (md - sh) % md : sh; ov = int'(sh == sb); end
         6:  begin full = sh + 1; r = full % md; c = int'(full >= md); ov = int'(sh == sb - 1); end
         7:  begin full = sh + 2; r = full % md; c = int'(full >= md);
                   ov = int'(sh == sb - 1 || sh == sb - 2); end
         8:  begin r = (sh - 1 + md) % md; c = int'(sh != 0); ov = int'(sh == sb); end
         9:  begin r = (sh - 2 + md) % md; c = int'(sh >= 2); ov = int'(sh == sb || sh == sb + 1); end
         10: r = dh | sh;
         11: r = dh & ~sh & (md - 1);
         12: r = dh ^ sh;
         13: r = sh;
         14: r = 0;
         default: r = md - 1;
      endcase
      if (o == 2) begin
         lgt = int'(sh > dh);
         agt = int'(to_signed(sh, sb, md) > to_signed(dh, sb, md));
         eq  = int'(sh == dh);
         par = parity(sh);
      end else if (o == 5) begin
         lgt = int'(sh != 0);
         agt = int'(sh != 0 && (sh & sb) == 0);
         eq  = int'(sh == 0);
         par = 0;
      end else begin
         lgt = int'(r != 0);
         agt = int'(r != 0 && (r & sb) == 0);
         eq  = int'(r == 0);
         par = parity(r);
      end
      case (o)
         0, 1, 4, 6, 7, 8, 9:   msk = 'hF8;
         5:                     msk = 'hE8;
         14, 15:                msk = 'h00;
         default:               msk = 'hE0;
      endcase
      if (bm) msk |= 'h04;
      xst = ((st & ~msk) | (((lgt << 7) | (agt << 6) | (eq << 5) | (c << 4) | (ov << 3) | (par << 2)) & msk)) & 'hFE;
      xr  = bm ? ((r << 8) | (d & 255)) : r;
      xwe = (o != 2);
   endtask

   task automatic drive(input int o, input bit bs, input int s, input int d, input int st);
      @(negedge clk);
      in_valid = 1'b1;
      op = o[3:0];
      byte_sel = bs;
      src = s[15:0];
      dst = d[15:0];
      st_in = st[7:0];
      @(posedge clk);
      #1;
   endtask

   task automatic expect_out(input string tag, input int xr, input bit xwe, input int xst);
      checks++;
      if (res_valid !== 1'b1 || res !== xr[15:0] || res_we !== xwe || st_out !== xst[7:0]) begin
         errors++;
         $display("FAIL %s: got valid=%0b res=%h we=%0b st=%h, expected valid=1 res=%h we=%0b st=%h",
                  tag, res_valid, res, res_we, st_out, xr[15:0], xwe, xst[7:0]);
      end
   endtask

   task automatic run_directed(input string tag, input int o, input bit bs, input int s,
                               input int d, input int st, input int xr, input bit xwe, input int xst);
      drive(o, bs, s, d, st);
      expect_out(tag, xr, xwe, xst);
   endtask

   function automatic string op_tag(int o, bit bm);
      if (bm) return "R10";
      case (o)
         0, 1, 6, 7, 8, 9: return "R4";
         2:  return "R6";
         3:  return "R7";
         4:  return "R9";
         5:  return "R8";
         default: return "R11";
      endcase
   endfunction

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #900000;
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got no completion, expected completion before timeout");
         finish_run();
      end
   end

   initial begin
      int cv[6] = '{'h0000, 'h0001, 'h7FFF, 'h8000, 'hAAAA, 'hFFFF};
      int starts[2] = '{'h20, 'hDC};
      int xr, xst;
      bit xwe;
      logic [15:0] held_res;
      logic [7:0]  held_st;

      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      checks++;
      if (res_valid !== 1'b0 || res_we !== 1'b0 || res !== 16'h0 || st_out !== 8'h0) begin
         errors++;
         $display("FAIL R1 reset: got valid=%0b we=%0b res=%h st=%h, expected 0 0 0000 00",
                  res_valid, res_we, res, st_out);
      end
      @(negedge clk);
      rst_n = 1'b1;

      // R4: signed overflow on add, borrow on subtract
      run_directed("R4 add overflow", 0, 0, 'h0001, 'h7FFF, 'h20, 'h8000, 1, 'h88);
      run_directed("R4 sub borrow",   1, 0, 'h0001, 'h0000, 'h20, 'hFFFF, 1, 'h80);
      // R5: flags from moved value
      run_directed("R5 move negative", 13, 0, 'h8000, 'h1234, 'h20, 'h8000, 1, 'h80);
      // R2: spare bit cleared, extended bit passed
      run_directed("R2 spare cleared", 13, 0, 'h0001, 'h0000, 'hFF, 'h0001, 1, 'hDE);
      run_directed("R2 xop kept",      14, 0, 'h5555, 'h0000, 'h02, 'h0000, 1, 'h02);
      // R7: invert keeps C OV P
      run_directed("R7 invert zero", 3, 0, 'h0000, 'h0000, 'hDC, 'hFFFF, 1, 'h9C);
      // R8: absolute value
      run_directed("R8 abs min",   5, 0, 'h8000, 'h0000, 'h20, 'h8000, 1, 'h88);
      run_directed("R8 abs minus1", 5, 0, 'hFFFF, 'h0000, 'hDC, 'h0001, 1, 'h94);
      // R9: negate zero
      run_directed("R9 neg zero", 4, 0, 'h0000, 'h0000, 'h20, 'h0000, 1, 'h30);
      // R6: compare, signed vs unsigned
      run_directed("R6 compare", 2, 0, 'h0001, 'hFFFF, 'h20, 'hFFFF, 0, 'h40);
      // R10: byte add of zeros clears parity, low byte kept
      run_directed("R10 byte add parity", 0, 1, 'h0000, 'h00AA, 'hDC, 'h00AA, 1, 'h20);
      run_directed("R10 byte sel ignored", 3, 1, 'h00FF, 'h0000, 'h20, 'hFF00, 1, 'h80);

      // R1: idle cycle holds outputs
      held_res = res;
      held_st  = st_out;
      @(negedge clk);
      in_valid = 1'b0;
      src = 16'h1111;
      st_in = 8'h55;
      @(posedge clk);
      #1;
      checks++;
      if (res_valid !== 1'b0 || res_we !== 1'b0 || res !== held_res || st_out !== held_st) begin
         errors++;
         $display("FAIL R1 idle: got valid=%0b we=%0b res=%h st=%h, expected 0 0 %h %h",
                  res_valid, res_we, res, st_out, held_res, held_st);
      end

      // R3 with R12 encodings: sweep every op, corner operand pair, start status, width
      for (int o = 0; o < 16; o++)
         for (int b = 0; b < 2; b++)
            for (int k = 0; k < 2; k++)
               for (int i = 0; i < 6; i++)
                  for (int j = 0; j < 6; j++) begin
                     model(o, b[0], cv[i], cv[j], starts[k], xr, xwe, xst);
                     drive(o, b[0], cv[i], cv[j], starts[k]);
                     expect_out($sformatf("R3/%s op%0d byte%0d src=%h dst=%h st=%h",
                                          op_tag(o, b[0] && (o == 0 || o == 1 || o == 2 ||
                                                 o == 10 || o == 11 || o == 13)),
                                          o, b, cv[i], cv[j], starts[k]),
                                xr, xwe, xst);
                  end

      @(negedge clk);
      in_valid = 1'b0;
      finish_run();
   end
endmodule